// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects interrupt requests from on-chip peripherals and from external pins and turns them into two processor request lines. A dedicated fast-interrupt pin alone drives the fast request. Every other source feeds the normal request through a priority encoder with eight levels.

Each normal source has its own configuration:
- an enable (mask) bit;
- a three-bit priority;
- a choice between level and edge detection;
- an active polarity.

Software reads the vector of the winning source from a combinational vector port. A read strobe acknowledges that source: it clears the source's edge latch and marks the source's priority level as in service. An end-of-interrupt strobe retires the most recent in-service level. While a level is in service, only sources at a strictly higher level can raise the normal request again. This gives nested preemption.

Top module: `pvic_top`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, every source is masked, and `vec_o` shows the spurious code, which equals NSRC (8 by default).
- R2: `fiq_o` equals the value `fiq_pin_i` had one clock earlier. No normal-source configuration or activity changes it.
- R3: `irq_o` is high in the cycle after at least one normal source is eligible, and low otherwise. A source with enable 0 never makes `irq_o` high or `vec_o` point to it.
- R4: In level mode (`cfg_edge_i`=0), a source is pending exactly while its input is at the active level. Polarity 1 means high is active and polarity 0 means low is active. Its vector appears and disappears in the same cycle as the input.
- R5: In edge mode (`cfg_edge_i`=1), a transition to the active polarity sets a latch one clock later. Polarity 1 means a rising edge and polarity 0 means a falling edge. The source stays pending after the input goes inactive again, until it is acknowledged.
- R6: `vec_o` gives the index of the eligible source with the numerically largest priority (7 is the highest). Among equal priorities, the lowest index wins.
- R7: A `vec_rd_i` pulse while a valid vector is shown clears that source's edge latch and puts its priority level in service. From then on, only sources with a strictly higher priority are eligible.
- R8: An `eoi_i` pulse removes the highest level in service. Sources above the next lower in-service level become eligible again.
- R9: When no source is eligible, `vec_o` shows the spurious code. This includes a source that was pending and then vanished before the read. A `vec_rd_i` pulse at that time changes no in-service state.
- R10: A configuration write to a source clears its edge latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Normal interrupt source inputs |
| fiq_pin_i | input | 1 | Dedicated fast interrupt pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source index for the configuration write |
| cfg_en_i | input | 1 | Enable bit written (1 means unmasked) |
| cfg_edge_i | input | 1 | Detection mode written (1 means edge, 0 means level) |
| cfg_pol_i | input | 1 | Polarity written (1 means high/rising, 0 means low/falling) |
| cfg_prio_i | input | 3 | Priority level written |
| vec_rd_i | input | 1 | Vector read and acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| vec_o | output | VEC_W | Winning source index, or NSRC when spurious |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its defaults: eight sources, so the spurious code is 8 and a three-bit index reaches every source. Eight sources are enough to fill all eight priority levels, to give two sources the same level for the tie-break, and to nest the in-service stack two deep and then unwind it. Directed sequences cover masking, both detection modes, both polarities, preemption, a vanished request and a latch cleared by a configuration write. A cycle-level reference model then follows several thousand random cycles in which configuration writes, reads and end-of-interrupt strobes interleave.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int LEVELS = 8;
  localparam int PRIO_W = $clog2(LEVELS);

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  valid;
    prio_t lvl;
  } lvl_t;

  // active transition detector: pol=1 rising, pol=0 falling
  function automatic logic edge_hit(logic pol, logic now, logic was);
    return pol ? (now & ~was) : (~now & was);
  endfunction

  // active level detector: pol=1 high, pol=0 low
  function automatic logic level_hit(logic pol, logic now);
    return pol ? now : ~now;
  endfunction

  // highest level currently marked in service
  function automatic lvl_t top_level(logic [LEVELS-1:0] isr);
    lvl_t r;
    r = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (isr[l]) begin
        r.valid = 1'b1;
        r.lvl   = prio_t'(l);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pvic_src_cell.sv
module pvic_src_cell
  import pvic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  src_i,
  input  logic  cfg_we_i,
  input  logic  cfg_en_i,
  input  logic  cfg_edge_i,
  input  logic  cfg_pol_i,
  input  prio_t cfg_prio_i,
  input  logic  ack_i,
  output logic  pend_o,
  output prio_t prio_o
);
  logic  en_q, edge_q, pol_q, prev_q, latch_q;
  prio_t prio_q;
  logic  edge_seen;

  assign edge_seen = en_q & edge_q & edge_hit(pol_q, src_i, prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      edge_q  <= 1'b0;
      pol_q   <= 1'b1;
      prio_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (cfg_we_i) begin
        en_q    <= cfg_en_i;
        edge_q  <= cfg_edge_i;
        pol_q   <= cfg_pol_i;
        prio_q  <= cfg_prio_i;
        latch_q <= 1'b0;
      end else if (edge_seen) begin
        latch_q <= 1'b1;
      end else if (ack_i) begin
        latch_q <= 1'b0;
      end
    end
  end

  assign pend_o = en_q & (edge_q ? latch_q : level_hit(pol_q, src_i));
  assign prio_o = prio_q;

  // R7: acknowledge without a fresh edge empties the latch
  assert_ack_clears_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !edge_seen) |=> !latch_q);
  // R5: a latched edge stays until acknowledge or reconfiguration
  assert_latch_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !ack_i && !cfg_we_i) |=> latch_q);
  // R10: configuration write empties the latch
  assert_cfg_clears_latch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !latch_q);
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC-1:0]        elig_i,
  input  prio_t [NSRC-1:0]       prio_i,
  output logic                   win_valid_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output prio_t                  win_prio_o
);
  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    prio_t            prio;
  } win_t;

  // descending scan with >= leaves the lowest index among equal levels
  function automatic win_t pick(logic [NSRC-1:0] el, prio_t [NSRC-1:0] pr);
    win_t w;
    w = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (el[i] && (!w.valid || pr[i] >= w.prio)) begin
        w.valid = 1'b1;
        w.idx   = IDX_W'(i);
        w.prio  = pr[i];
      end
    end
    return w;
  endfunction

  win_t win;
  assign win         = pick(elig_i, prio_i);
  assign win_valid_o = win.valid;
  assign win_idx_o   = win.idx;
  assign win_prio_o  = win.prio;

  // R6: the winner is itself eligible and carries its own level
  assert_winner_eligible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (elig_i[win_idx_o] && prio_i[win_idx_o] == win_prio_o));
  // R9: no eligible source means no winner
  assert_no_winner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i == '0) |-> !win_valid_o);
endmodule

// File: rtl/pvic_level_stack.sv
module pvic_level_stack
  import pvic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  prio_t push_lvl_i,
  input  logic  pop_i,
  output logic  cur_valid_o,
  output prio_t cur_lvl_o
);
  logic [LEVELS-1:0] isr_q, isr_n;
  lvl_t top;

  assign top = top_level(isr_q);

  always_comb begin
    isr_n = isr_q;
    if (pop_i && top.valid) isr_n[top.lvl] = 1'b0;
    if (push_i) isr_n[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_n;
  end

  assign cur_valid_o = top.valid;
  assign cur_lvl_o   = top.lvl;

  // R7: an acknowledged level is in service afterwards
  assert_push_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> isr_q[$past(push_lvl_i)]);
  // R8: end of interrupt retires exactly one level
  assert_pop_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && top.valid) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC),
  parameter int VEC_W = $clog2(NSRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic             fiq_pin_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_en_i,
  input  logic             cfg_edge_i,
  input  logic             cfg_pol_i,
  input  logic [2:0]       cfg_prio_i,
  input  logic             vec_rd_i,
  input  logic             eoi_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam logic [VEC_W-1:0] SPURIOUS = VEC_W'(NSRC);

  logic [NSRC-1:0]  pend, elig;
  prio_t [NSRC-1:0] prio;
  logic             sel_valid, vec_ack, cur_valid;
  logic [IDX_W-1:0] sel_idx;
  prio_t            sel_prio, cur_lvl;
  logic             irq_q, fiq_q;

  assign vec_ack = vec_rd_i & sel_valid;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pvic_src_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[g]),
      .cfg_we_i   (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
      .cfg_en_i   (cfg_en_i),
      .cfg_edge_i (cfg_edge_i),
      .cfg_pol_i  (cfg_pol_i),
      .cfg_prio_i (prio_t'(cfg_prio_i)),
      .ack_i      (vec_ack && (sel_idx == IDX_W'(g))),
      .pend_o     (pend[g]),
      .prio_o     (prio[g])
    );
    assign elig[g] = pend[g] & (!cur_valid || (prio[g] > cur_lvl));
  end

  pvic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .elig_i      (elig),
    .prio_i      (prio),
    .win_valid_o (sel_valid),
    .win_idx_o   (sel_idx),
    .win_prio_o  (sel_prio)
  );

  pvic_level_stack u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (vec_ack),
    .push_lvl_i  (sel_prio),
    .pop_i       (eoi_i),
    .cur_valid_o (cur_valid),
    .cur_lvl_o   (cur_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |elig;
      fiq_q <= fiq_pin_i;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
  assign vec_o = sel_valid ? VEC_W'(sel_idx) : SPURIOUS;

  // R2: fast request is a one-cycle copy of its pin
  assert_fiq_follows_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_pin_i |=> fiq_o);
  assert_fiq_quiet_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_pin_i |=> !fiq_o);
  // R3: nothing pending, no normal request next cycle
  assert_irq_needs_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |=> !irq_o);
  // R7: a winner always lies above the level in service
  assert_strict_preempt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid && cur_valid) |-> (sel_prio > cur_lvl));
  // R9: a read with the spurious code leaves the service state untouched
  assert_spurious_no_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && vec_o == SPURIOUS && !eoi_i) |=> ($stable(cur_valid) && $stable(cur_lvl)));
endmodule

// File: tb/pvic_top_tb_top.sv
`timescale 1ns/1ps
module pvic_top_tb_top;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       fiq_pin = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic       cfg_en = 1'b0, cfg_edge = 1'b0, cfg_pol = 1'b1;
  logic [2:0] cfg_prio = '0;
  logic       vec_rd = 1'b0, eoi = 1'b0;
  logic [3:0] vec_o;
  logic       irq_o, fiq_o;

  int n_chk = 0, n_bad = 0;

  // reference state
  bit       m_en[NS], m_edge[NS], m_pol[NS], m_prev[NS], m_latch[NS];
  int       m_prio[NS];
  bit [7:0] m_isr = '0;
  bit       m_irq = 0, m_fiq = 0;

  always #2.5 clk = ~clk;

  pvic_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .fiq_pin_i(fiq_pin),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
    .cfg_edge_i(cfg_edge), .cfg_pol_i(cfg_pol), .cfg_prio_i(cfg_prio),
    .vec_rd_i(vec_rd), .eoi_i(eoi), .vec_o(vec_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int in_service();
    int cur = -1;
    for (int l = 0; l < 8; l++) if (m_isr[l]) cur = l;
    return cur;
  endfunction

  // ascending scan, strictly greater: first index keeps ties
  function automatic int best_of(bit [7:0] el);
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (el[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  task automatic tick();
    int cur, best;
    bit [7:0] elig;
    #1;
    cur = in_service();
    elig = '0;
    for (int i = 0; i < NS; i++) begin
      bit act, pend;
      act = m_pol[i] ? src[i] : !src[i];
      pend = m_en[i] && (m_edge[i] ? m_latch[i] : act);
      elig[i] = pend && (m_prio[i] > cur);
    end
    best = best_of(elig);
    check(int'(vec_o), (best < 0) ? NS : best, "R6 vector model");
    check(int'(irq_o), int'(m_irq), "R3 irq model");
    check(int'(fiq_o), int'(m_fiq), "R2 fiq model");
    if (eoi && cur >= 0) m_isr[cur] = 1'b0;
    if (vec_rd && best >= 0) m_isr[m_prio[best]] = 1'b1;
    for (int i = 0; i < NS; i++) begin
      bit eh;
      eh = m_en[i] && m_edge[i] &&
           (m_pol[i] ? (src[i] && !m_prev[i]) : (!src[i] && m_prev[i]));
      if (cfg_we && int'(cfg_idx) == i) begin
        m_latch[i] = 0; m_en[i] = cfg_en; m_edge[i] = cfg_edge;
        m_pol[i] = cfg_pol; m_prio[i] = int'(cfg_prio);
      end else if (eh) m_latch[i] = 1;
      else if (vec_rd && best == i) m_latch[i] = 0;
      m_prev[i] = src[i];
    end
    m_irq = |elig;
    m_fiq = fiq_pin;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cfg(int idx, bit en, bit edg, bit pol, int pr);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_edge = edg;
    cfg_pol = pol; cfg_prio = 3'(pr);
    tick();
    cfg_we = 0;
  endtask

  task automatic do_ack();
    vec_rd = 1; tick(); vec_rd = 0;
  endtask

  task automatic do_eoi();
    eoi = 1; tick(); eoi = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < NS; i++) begin
      m_en[i] = 0; m_edge[i] = 0; m_pol[i] = 1; m_prev[i] = 0; m_latch[i] = 0; m_prio[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(int'(irq_o), 0, "R1 irq after reset");
    check(int'(fiq_o), 0, "R1 fiq after reset");
    check(int'(vec_o), NS, "R1 spurious after reset");

    // R4 level, active high
    do_cfg(2, 1, 0, 1, 3);
    check(int'(vec_o), NS, "R4 inactive level");
    src[2] = 1; tick();
    check(int'(vec_o), 2, "R4 active level");
    check(int'(irq_o), 1, "R3 irq raised");
    src[2] = 0; #1;
    check(int'(vec_o), NS, "R4 level released");
    tick();
    // R3 masked source ignored
    do_cfg(2, 0, 0, 1, 3);
    src[2] = 1; tick(); tick();
    check(int'(vec_o), NS, "R3 masked vector");
    check(int'(irq_o), 0, "R3 masked irq");
    // R5 falling-edge latch
    do_cfg(5, 1, 1, 0, 4);
    src[5] = 1; tick();
    src[5] = 0; tick();
    src[5] = 1; tick();
    check(int'(vec_o), 5, "R5 edge latched");
    // R6 tie and priority
    do_cfg(1, 1, 0, 1, 4);
    src[1] = 1; tick();
    check(int'(vec_o), 1, "R6 tie lowest index");
    do_cfg(6, 1, 0, 1, 6);
    src[6] = 1; tick();
    check(int'(vec_o), 6, "R6 highest priority");
    // R7 acknowledge and preemption
    do_ack();
    check(int'(vec_o), NS, "R7 lower levels blocked");
    do_cfg(3, 1, 0, 1, 7);
    src[3] = 1; tick();
    check(int'(vec_o), 3, "R7 higher level preempts");
    do_ack();
    check(int'(vec_o), NS, "R7 nested in service");
    // R8 unwind
    do_eoi();
    check(int'(vec_o), 3, "R8 pop top level");
    src[3] = 0; do_eoi();
    check(int'(vec_o), 6, "R8 pop next level");
    src[6] = 0; src[1] = 0; tick();
    check(int'(vec_o), 5, "R5 latch survives");
    do_ack(); do_eoi();
    check(int'(vec_o), NS, "R7 ack clears latch");
    // R9 vanished request
    src[1] = 1; tick();
    check(int'(vec_o), 1, "R9 before vanish");
    src[1] = 0; vec_rd = 1; #1;
    check(int'(vec_o), NS, "R9 spurious code");
    tick(); vec_rd = 0;
    src[1] = 1; tick();
    check(int'(vec_o), 1, "R9 no level pushed");
    // R10 configuration clears latch
    src[1] = 0; src[5] = 0; tick();
    src[5] = 1; tick();
    check(int'(vec_o), 5, "R10 latch set");
    do_cfg(5, 1, 1, 0, 4);
    check(int'(vec_o), NS, "R10 latch cleared");
    // R2 fast pin
    fiq_pin = 1; tick();
    check(int'(fiq_o), 1, "R2 fiq high");
    fiq_pin = 0; tick();
    check(int'(fiq_o), 0, "R2 fiq low");

    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < NS; b++) if ($urandom_range(3) == 0) src[b] = ~src[b];
      fiq_pin = ($urandom_range(3) == 0);
      vec_rd = ($urandom_range(3) == 0);
      eoi = ($urandom_range(5) == 0);
      cfg_we = ($urandom_range(15) == 0);
      cfg_idx = 3'($urandom_range(7));
      cfg_en = ($urandom_range(4) != 0);
      cfg_edge = $urandom_range(1);
      cfg_pol = $urandom_range(1);
      cfg_prio = 3'($urandom_range(7));
      tick();
    end
    vec_rd = 0; eoi = 0; cfg_we = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule